// File: doc/BRIEF.md
# I2C Start/Stop Condition Controller

This block is the master-side condition generator of an I2C controller. Software requests a start, a repeated start or a stop through one 8-bit control/status register. The request is a single write that combines a bus-busy bit with an active-low command strobe bit. With the strobe at 0, writing busy as 1 asks for a start and writing busy as 0 asks for a stop. With the strobe at 1, the write asks for no bus condition at all. The strobe bit is never stored and always reads back as 1.

The controller drives the bus through open-drain output enables, where 1 pulls the line low. Each step of a sequence advances only on a half-period tick from an external clock divider. A start (also used for a repeated start) runs in this order:

1. Release SDA.
2. Release SCL.
3. Pull SDA low while SCL is high.
4. Pull SCL low.

A stop runs in this order:

1. Make sure SCL is low.
2. Pull SDA low.
3. Release SCL.
4. Release SDA while SCL is high.

The controller also watches both lines through two-flop synchronizers and decodes start and stop events, whichever master caused them. From these events it keeps a bus-busy flag and two sticky status flags: start established and stop seen.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset the register reads 8'h01 and both output enables are 0 (lines released). Register bits are: bit0 command strobe (active low), bit1 bus busy, bit2 master, bit3 transmit, bit4 start established, bit5 stop seen, bits 7:6 zero.
- R2: A write with bit1=1 and bit0=0, made while no sequence runs, produces on the bus SDA falling while SCL is high. Both lines are then held low, and the register reads busy, master, transmit and start-established all set.
- R3: After a start request, until the start is seen on the bus, the busy bit reads 0.
- R4: A start request written while the bus is already busy and held low by this master produces another SDA fall while SCL is high, with no stop in between. Busy stays 1.
- R5: A write with bit1=0 and bit0=0 produces SDA rising while SCL is high and leaves both lines released. The register then reads busy, master and transmit cleared and stop-seen set.
- R6: A write with bit0=1 starts no sequence and leaves both output enables unchanged.
- R7: Bit0 reads as 1 at all times, whatever was written.
- R8: Busy is set by any start event and cleared by any stop event seen on the synchronized lines, including events caused by another master. Start-established is set only while the master bit is 1.
- R9: A status flag (bit4 or bit5) is cleared by writing 0 to it only if it was read as 1 since the last accepted write. Otherwise it stays 1.
- R10: Register writes made while a sequence is running are ignored.
- R11: A running sequence moves to its next bus step only on a tick. Without ticks the output enables stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Half-bit-period pulse from the clock divider |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |

## Verification
On every cycle the assertions check four things: the strobe bit reads 1, busy follows the decoded start and stop events, a flag that is not armed cannot be cleared, and a running sequence holds still between ticks. They also check that finishing a start leaves both lines low, that finishing a stop leaves both lines released, and that writes during a sequence leave the master bit alone. The bench scenarios show the bus-level order of line changes, which only the open-drain bus model in the bench can observe. They also cover the busy bit staying low while a start is pending, repeated starts with no stop in between, and the read-then-write clearing protocol. Finally, they show busy tracking for conditions created by a different master.

// File: rtl/i2c_cond_pkg.sv
// Package: shared register field positions and sequencer state encoding
// for the I2C start/stop condition controller.
package i2c_cond_pkg;

    localparam int unsigned CSR_W          = 8;
    localparam int unsigned F_STROBE_N     = 0;
    localparam int unsigned F_BUSY         = 1;
    localparam int unsigned F_MASTER       = 2;
    localparam int unsigned F_XMIT         = 3;
    localparam int unsigned F_START_SEEN   = 4;
    localparam int unsigned F_STOP_SEEN    = 5;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_RS_SDA  = 3'd1,  // release SDA, SCL unchanged
        SQ_RS_SCL  = 3'd2,  // SDA and SCL released
        SQ_ST_SDA  = 3'd3,  // SDA low, SCL released
        SQ_SP_PULL = 3'd4,  // SCL forced low
        SQ_SP_SCL  = 3'd5,  // SDA low, SCL low
        SQ_SP_SDA  = 3'd6   // SDA low, SCL released
    } seq_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Synchronizes the raw SDA/SCL levels through SYNC_STAGES flops and decodes
// start (SDA falling, SCL high) and stop (SDA rising, SCL high) events.
// Assumes the lines idle high; the sync chain resets to 1.
module i2c_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic scl_in,
    output logic start_det,
    output logic stop_det
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sda_pipe;
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic                   sda_prev;
    logic                   scl_prev;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the asynchronous line levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        sda_pipe[0] <= 1'b1;
                        scl_pipe[0] <= 1'b1;
                    end else begin
                        sda_pipe[0] <= sda_in;
                        scl_pipe[0] <= scl_in;
                    end
                end
            end else begin : g_next
                // Shift the levels further down the synchronizer.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        sda_pipe[g] <= 1'b1;
                        scl_pipe[g] <= 1'b1;
                    end else begin
                        sda_pipe[g] <= sda_pipe[g-1];
                        scl_pipe[g] <= scl_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    // Keep the previous synchronized levels for edge decoding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_prev <= 1'b1;
            scl_prev <= 1'b1;
        end else begin
            sda_prev <= sda_pipe[LAST];
            scl_prev <= scl_pipe[LAST];
        end
    end

    // Decode the bus conditions from the synchronized edges.
    always_comb begin
        start_det = sda_prev & ~sda_pipe[LAST] & scl_prev & scl_pipe[LAST];
        stop_det  = ~sda_prev & sda_pipe[LAST] & scl_prev & scl_pipe[LAST];
    end

endmodule

// File: rtl/i2c_cond_seq.sv
// Module: i2c_cond_seq
// Steps the open-drain output enables through the start or stop order, one
// step per tick. Accepts a command only when idle. Between sequences it
// holds the last enables (lines low after a start, released after a stop).
module i2c_cond_seq
    import i2c_cond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic go_start,
    input  logic go_stop,
    output logic active,
    output logic sda_oe,
    output logic scl_oe
);
    seq_state_t state;

    // Advance the condition sequence and update the line enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (go_start) begin
                        sda_oe <= 1'b0;
                        state  <= SQ_RS_SDA;
                    end else if (go_stop) begin
                        scl_oe <= 1'b1;
                        state  <= SQ_SP_PULL;
                    end
                end
                SQ_RS_SDA: if (tick) begin
                    scl_oe <= 1'b0;
                    state  <= SQ_RS_SCL;
                end
                SQ_RS_SCL: if (tick) begin
                    sda_oe <= 1'b1;
                    state  <= SQ_ST_SDA;
                end
                SQ_ST_SDA: if (tick) begin
                    scl_oe <= 1'b1;
                    state  <= SQ_IDLE;
                end
                SQ_SP_PULL: if (tick) begin
                    sda_oe <= 1'b1;
                    state  <= SQ_SP_SCL;
                end
                SQ_SP_SCL: if (tick) begin
                    scl_oe <= 1'b0;
                    state  <= SQ_SP_SDA;
                end
                SQ_SP_SDA: if (tick) begin
                    sda_oe <= 1'b0;
                    state  <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Report whether a sequence is in flight.
    always_comb active = (state != SQ_IDLE);

    assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && !tick) |=> ($stable(state) && $stable(sda_oe) && $stable(scl_oe)));

    assert_start_ends_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ST_SDA && tick) |=> (sda_oe && scl_oe && state == SQ_IDLE));

    assert_stop_ends_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SP_SDA && tick) |=> (!sda_oe && !scl_oe));

endmodule

// File: rtl/i2c_cond_regs.sv
// Module: i2c_cond_regs
// Control/status register. Decodes the busy/strobe command write, keeps the
// master, transmit and busy state, and holds the sticky start/stop flags
// with read-then-write-0 clearing. Ignores writes while a sequence runs.
module i2c_cond_regs
    import i2c_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CSR_W-1:0] reg_wdata,
    output logic [CSR_W-1:0] reg_rdata,
    input  logic             seq_active,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             go_start,
    output logic             go_stop
);
    logic busy_q;
    logic master_q;
    logic xmit_q;
    logic start_seen_q;
    logic stop_seen_q;
    logic start_arm_q;
    logic stop_arm_q;
    logic wr_ok;
    logic cmd;

    // Qualify writes and decode the condition command.
    always_comb begin
        wr_ok    = reg_wr & ~seq_active;
        cmd      = wr_ok & ~reg_wdata[F_STROBE_N];
        go_start = cmd & reg_wdata[F_BUSY];
        go_stop  = cmd & ~reg_wdata[F_BUSY];
    end

    // Track bus busy from decoded bus events.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (start_det) busy_q <= 1'b1;
        else if (stop_det)  busy_q <= 1'b0;
    end

    // Set master/transmit on a start request; drop them on a stop event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            xmit_q   <= 1'b0;
        end else if (go_start) begin
            master_q <= 1'b1;
            xmit_q   <= 1'b1;
        end else if (stop_det) begin
            master_q <= 1'b0;
            xmit_q   <= 1'b0;
        end
    end

    // Sticky start-established flag with armed clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_seen_q <= 1'b0;
            start_arm_q  <= 1'b0;
        end else begin
            if (start_det && master_q)
                start_seen_q <= 1'b1;
            else if (wr_ok && start_arm_q && !reg_wdata[F_START_SEEN])
                start_seen_q <= 1'b0;
            if (wr_ok)
                start_arm_q <= 1'b0;
            else if (reg_rd && start_seen_q)
                start_arm_q <= 1'b1;
        end
    end

    // Sticky stop-seen flag with armed clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_seen_q <= 1'b0;
            stop_arm_q  <= 1'b0;
        end else begin
            if (stop_det)
                stop_seen_q <= 1'b1;
            else if (wr_ok && stop_arm_q && !reg_wdata[F_STOP_SEEN])
                stop_seen_q <= 1'b0;
            if (wr_ok)
                stop_arm_q <= 1'b0;
            else if (reg_rd && stop_seen_q)
                stop_arm_q <= 1'b1;
        end
    end

    // Assemble the read view; the strobe position is constant 1.
    always_comb begin
        reg_rdata               = '0;
        reg_rdata[F_STROBE_N]   = 1'b1;
        reg_rdata[F_BUSY]       = busy_q;
        reg_rdata[F_MASTER]     = master_q;
        reg_rdata[F_XMIT]       = xmit_q;
        reg_rdata[F_START_SEEN] = start_seen_q;
        reg_rdata[F_STOP_SEEN]  = stop_seen_q;
    end

    assert_strobe_reads_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[F_STROBE_N]);

    assert_busy_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> reg_rdata[F_BUSY]);

    assert_idle_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !reg_rdata[F_BUSY]);

    assert_flag_needs_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen_q && !stop_arm_q) |=> stop_seen_q);

    assert_write_ignored_in_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && reg_wr && !stop_det) |=> $stable(master_q));

endmodule

// File: rtl/i2c_cond_ctrl.sv
// Module: i2c_cond_ctrl
// Top of the I2C start/stop condition controller: line synchronizer, condition
// sequencer and control/status register. Assumes an external open-drain bus
// where an output enable of 1 pulls the line low.
module i2c_cond_ctrl
    import i2c_cond_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic       sda_oe,
    output logic       scl_oe
);
    logic start_det;
    logic stop_det;
    logic go_start;
    logic go_stop;
    logic seq_active;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_cond_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .go_start (go_start),
        .go_stop  (go_stop),
        .active   (seq_active),
        .sda_oe   (sda_oe),
        .scl_oe   (scl_oe)
    );

    i2c_cond_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .seq_active (seq_active),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .go_start   (go_start),
        .go_stop    (go_stop)
    );

endmodule

// File: tb/i2c_cond_ctrl_bench.sv
// Directed bench for i2c_cond_ctrl with an open-drain bus model and a
// bus-event counter of its own.
module i2c_cond_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tick_en = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sda_oe, scl_oe;
    logic       ext_sda = 1'b0;
    logic       ext_scl = 1'b0;
    logic       sda_bus, scl_bus;
    logic       sda_prev = 1'b1, scl_prev = 1'b1;
    int         n_start = 0, n_stop = 0;
    int         n_checks = 0, n_fail = 0;
    int         tick_cnt = 0;

    always #5 clk = ~clk;

    assign sda_bus = !(sda_oe || ext_sda);
    assign scl_bus = !(scl_oe || ext_scl);

    i2c_cond_ctrl u_i2c_cond_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sda_in(sda_bus), .scl_in(scl_bus), .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    // Divider tick: one pulse every 8 cycles while enabled.
    always @(posedge clk) begin
        if (!tick_en) begin
            tick_cnt <= 0;
            tick     <= 1'b0;
        end else begin
            tick_cnt <= (tick_cnt == 7) ? 0 : tick_cnt + 1;
            tick     <= (tick_cnt == 7);
        end
    end

    // Independent bus monitor counting start and stop events.
    always @(posedge clk) begin
        if (sda_prev && !sda_bus && scl_prev && scl_bus) n_start <= n_start + 1;
        if (!sda_prev && sda_bus && scl_prev && scl_bus) n_stop  <= n_stop + 1;
        sda_prev <= sda_bus;
        scl_prev <= scl_bus;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check(reg_rdata == 8'h01, "R1 reset rdata", reg_rdata, 8'h01);
        check(!sda_oe && !scl_oe, "R1 reset oe", {sda_oe, scl_oe}, 0);
    endtask

    task automatic t_noop_strobe();
        int s0 = n_start;
        wr(8'h33);
        idle(40);
        check(!sda_oe && !scl_oe && n_start == s0, "R6 no condition", {sda_oe, scl_oe}, 0);
        check(reg_rdata == 8'h01, "R7 strobe reads 1", reg_rdata, 8'h01);
    endtask

    task automatic t_first_start();
        int s0 = n_start;
        tick_en = 1'b0;
        wr(8'h32);
        idle(20);
        check(!reg_rdata[1], "R3 busy low while pending", reg_rdata[1], 0);
        check(!sda_oe && !scl_oe, "R11 no step without tick", {sda_oe, scl_oe}, 0);
        tick_en = 1'b1;
        for (int i = 0; i < 300 && !(sda_oe && scl_oe && reg_rdata[1]); i++) @(negedge clk);
        check(n_start == s0 + 1, "R2 start on bus", n_start - s0, 1);
        check(sda_oe && scl_oe, "R2 lines held low", {sda_oe, scl_oe}, 3);
        check(reg_rdata == 8'h1F, "R2 status after start", reg_rdata, 8'h1F);
    endtask

    task automatic t_repeat_start();
        int s0 = n_start;
        int p0 = n_stop;
        wr(8'h32);
        wr(8'h30);
        idle(3);
        check(!scl_oe || !sda_oe, "R10 sequence running", {sda_oe, scl_oe}, 1);
        for (int i = 0; i < 300 && !(sda_oe && scl_oe && n_start == s0 + 1); i++) @(negedge clk);
        idle(60);
        check(n_start == s0 + 1, "R4 repeated start", n_start - s0, 1);
        check(n_stop == p0, "R10 stop write ignored", n_stop - p0, 0);
        check(reg_rdata == 8'h1F && sda_oe && scl_oe, "R4 still busy", reg_rdata, 8'h1F);
    endtask

    task automatic t_flag_clear();
        wr(8'h23);
        check(reg_rdata[4], "R9 unarmed clear ignored", reg_rdata[4], 1);
        rd();
        wr(8'h23);
        check(reg_rdata == 8'h0F, "R9 armed clear", reg_rdata, 8'h0F);
    endtask

    task automatic t_stop();
        int p0 = n_stop;
        wr(8'h30);
        for (int i = 0; i < 300 && !(reg_rdata[5] && !sda_oe && !scl_oe); i++) @(negedge clk);
        check(n_stop == p0 + 1, "R5 stop on bus", n_stop - p0, 1);
        check(!sda_oe && !scl_oe, "R5 lines released", {sda_oe, scl_oe}, 0);
        check(reg_rdata == 8'h21, "R5 status after stop", reg_rdata, 8'h21);
    endtask

    task automatic t_external();
        rd();
        wr(8'h01);
        check(reg_rdata == 8'h01, "R9 stop flag cleared", reg_rdata, 8'h01);
        @(negedge clk); ext_sda = 1'b1;
        idle(10);
        check(reg_rdata == 8'h03, "R8 foreign start sets busy", reg_rdata, 8'h03);
        @(negedge clk); ext_sda = 1'b0;
        idle(10);
        check(reg_rdata == 8'h21, "R8 foreign stop clears busy", reg_rdata, 8'h21);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_noop_strobe();
        t_first_start();
        t_repeat_start();
        t_flag_clear();
        t_stop();
        t_external();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule